// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller with Transient States

This block keeps the coherence state of every line of a small direct-mapped, write-back cache on an atomic snooping bus. The processor side presents one access at a time (read or write). A hit that already has enough permission finishes in the same cycle. A miss or a missing write permission parks the line in a pending state and raises a bus request. The pending state is shared-to-modified for an upgrade, invalid-to-modified for a read-for-ownership, and invalid-to-shared for a plain read. The processor stays stalled until the bus grants and completes the transaction.

The bus side watches other caches' transactions through its own copy of the tags and states. It reports whether this cache holds a copy, whether that copy is dirty and must be flushed, and whether the snoop has to wait. If a snooped transaction changes a line's state, the processor lookup in that same cycle is stalled.

Two races are resolved here. A queued upgrade that loses to another cache's exclusive request becomes a read-for-ownership. A line that has just become modified is held for one cycle, so that the processor's write is performed before any other request can take the line away.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is invalid: any first access misses, bus_req is low and cpu_done is low.
- R2: A read to a line whose tag matches in state S or M, or a write to a tag-matching line in M, raises cpu_done in the same cycle and issues no bus request.
- R3: A read miss raises bus_req from the next cycle with bus_cmd = 01 (read) and bus_addr equal to the request address. When bus_gnt and bus_done are both high, cpu_done is high in that same cycle and the line becomes S.
- R4: A write to a tag-matching line in S requests with bus_cmd = 11 (upgrade). Any other write without permission requests with bus_cmd = 10 (read-for-ownership). After bus_gnt and bus_done, the line is M and cpu_done is high in the following cycle only.
- R5: If a read-for-ownership or an upgrade from another cache is snooped to a line with a pending upgrade, the line drops to the invalid-to-modified state, and from the next cycle bus_cmd reads 10.
- R6: A snooped read (snp_cmd = 01) to a line in M raises snp_dirty and snp_shared and leaves the line in S. A later write to it therefore needs an upgrade.
- R7: A snooped read-for-ownership (10) or upgrade (11) to a line in S or M invalidates it. snp_shared is high for a tag-matching line in S, M or pending upgrade, and snp_dirty is high only for M.
- R8: In the cycle after a write's bus completion, a snoop to that line raises snp_wait, raises neither snp_shared nor snp_dirty, and leaves the line in M.
- R9: In a cycle where a snoop changes a line's state, a processor access is not served (cpu_done low). It is served in the next cycle without the snoop.
- R10: bus_req is high only while a line is pending, and it is low in the cycle after bus_gnt and bus_done.
- R11: A snoop to a line with a pending read or read-for-ownership, or with a different tag, gives snp_shared = 0 and snp_dirty = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_done | output | 1 | Access performed this cycle |
| bus_req | output | 1 | Bus request for the pending line |
| bus_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 upgrade |
| bus_addr | output | ADDR_W | Line address of the pending request |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted transaction completes this cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a copy |
| snp_dirty | output | 1 | This cache holds the modified copy and flushes it |
| snp_wait | output | 1 | Snoop not serviced yet; retry |

## Verification
The bench builds the controller with ADDR_W = 8 and IDX_W = 2, which gives four lines. Addresses are drawn from three tags, so random traffic produces frequent conflict misses, tag mismatches on snoops, and repeated S/M/I transitions on every line. The small index also lets directed cases put a snoop and a processor access on different lines in the same cycle. This is how the update stall and the write hold are reached.

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_dirty,
  output logic              snp_wait
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] CMD_RD  = 2'b01;
  localparam logic [1:0] CMD_RDX = 2'b10;
  localparam logic [1:0] CMD_UPG = 2'b11;

  typedef enum logic [2:0] {ST_I, ST_S, ST_M, ST_SM, ST_IM, ST_IS} st_t;

  st_t              pst  [LINES];
  st_t              bst  [LINES];
  logic [TAG_W-1:0] ptag [LINES];
  logic [TAG_W-1:0] btag [LINES];

  logic             busy, hold, pend_we;
  logic [IDX_W-1:0] pend_idx;
  logic [TAG_W-1:0] pend_tag;

  // processor-side lookup
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic             c_match, c_hit, cpu_go, start_miss;
  st_t              c_st, miss_st;

  assign c_idx   = cpu_addr[IDX_W-1:0];
  assign c_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st    = pst[c_idx];
  assign c_match = ptag[c_idx] == c_tag;
  assign c_hit   = c_match && (c_st == ST_M || (!cpu_we && c_st == ST_S));
  assign miss_st = !cpu_we ? ST_IS : ((c_match && c_st == ST_S) ? ST_SM : ST_IM);

  // bus-side lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             own_xfer, s_active, s_held, s_upd;
  st_t              s_st, s_next;

  assign s_idx    = snp_addr[IDX_W-1:0];
  assign s_tag    = snp_addr[ADDR_W-1:IDX_W];
  assign s_st     = bst[s_idx];
  assign own_xfer = busy && !hold && bus_gnt && bus_done;
  assign s_active = snp_valid && !own_xfer && (btag[s_idx] == s_tag);
  assign s_held   = s_active && hold && (s_idx == pend_idx);

  always_comb begin
    s_next = s_st;
    case (s_st)
      ST_M:    s_next = (snp_cmd == CMD_RD) ? ST_S  : ST_I;
      ST_S:    s_next = (snp_cmd == CMD_RD) ? ST_S  : ST_I;
      ST_SM:   s_next = (snp_cmd == CMD_RD) ? ST_SM : ST_IM;
      default: s_next = s_st;
    endcase
  end

  assign s_upd      = s_active && !s_held && (snp_cmd != 2'b00) && (s_next != s_st);
  assign snp_wait   = s_held;
  assign snp_shared = s_active && !s_held &&
                      (s_st == ST_S || s_st == ST_M || s_st == ST_SM);
  assign snp_dirty  = s_active && !s_held && s_st == ST_M;

  // processor sequencing
  assign cpu_go     = cpu_req && !busy && !s_upd;
  assign start_miss = cpu_go && !c_hit;
  assign cpu_done   = (cpu_go && c_hit) || (own_xfer && !pend_we) || hold;

  // bus request
  assign bus_req  = busy && !hold;
  assign bus_addr = {pend_tag, pend_idx};
  always_comb begin
    bus_cmd = 2'b00;
    if (bus_req) begin
      case (pst[pend_idx])
        ST_IS:   bus_cmd = CMD_RD;
        ST_IM:   bus_cmd = CMD_RDX;
        ST_SM:   bus_cmd = CMD_UPG;
        default: bus_cmd = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        pst[i]  <= ST_I;
        bst[i]  <= ST_I;
        ptag[i] <= '0;
        btag[i] <= '0;
      end
      busy     <= 1'b0;
      hold     <= 1'b0;
      pend_we  <= 1'b0;
      pend_idx <= '0;
      pend_tag <= '0;
    end else begin
      hold <= own_xfer && pend_we;
      if (hold) busy <= 1'b0;
      if (own_xfer) begin
        pst[pend_idx] <= (pst[pend_idx] == ST_IS) ? ST_S : ST_M;
        bst[pend_idx] <= (pst[pend_idx] == ST_IS) ? ST_S : ST_M;
        if (!pend_we) busy <= 1'b0;
      end
      if (s_upd) begin
        pst[s_idx] <= s_next;
        bst[s_idx] <= s_next;
      end
      if (start_miss) begin
        pst[c_idx]  <= miss_st;
        bst[c_idx]  <= miss_st;
        ptag[c_idx] <= c_tag;
        btag[c_idx] <= c_tag;
        busy        <= 1'b1;
        pend_we     <= cpu_we;
        pend_idx    <= c_idx;
        pend_tag    <= c_tag;
      end
    end
  end

  p_req_transient_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (pst[pend_idx] == ST_SM || pst[pend_idx] == ST_IM || pst[pend_idx] == ST_IS));
  p_req_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_done) |=> !bus_req);
  p_race_rdx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == CMD_UPG && !(bus_gnt && bus_done) && snp_valid &&
     snp_addr == bus_addr && snp_cmd != CMD_RD && snp_cmd != 2'b00) |=> bus_cmd == CMD_RDX);
  p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_done && pend_we) |=> (cpu_done && !bus_req));
  p_wait_keeps_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wait |=> bst[pend_idx] == ST_M);
  p_update_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_upd && !busy) |-> !cpu_done);
  p_dirty_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> (snp_shared && !snp_wait));
endmodule

// File: tb/snoop_msi_ctrl_test.sv
module snoop_msi_ctrl_test;
  localparam int AW = 8;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_done = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_done, bus_req, snp_shared, snp_dirty, snp_wait;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0;
  int mst [4];
  int mtg [4];

  always #5 clk = ~clk;

  snoop_msi_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_wait(snp_wait));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int m_idx(input logic [AW-1:0] a); return int'(a[IW-1:0]); endfunction
  function automatic int m_tag(input logic [AW-1:0] a); return int'(a[AW-1:IW]); endfunction
  // 0 = I, 1 = S, 2 = M
  function automatic bit m_hit(input logic [AW-1:0] a, input bit we);
    int i = m_idx(a);
    if (mtg[i] != m_tag(a)) return 0;
    return we ? (mst[i] == 2) : (mst[i] != 0);
  endfunction
  function automatic logic [1:0] m_cmd(input logic [AW-1:0] a, input bit we);
    int i = m_idx(a);
    if (!we) return 2'b01;
    return (mtg[i] == m_tag(a) && mst[i] == 1) ? 2'b11 : 2'b10;
  endfunction

  task automatic step; @(posedge clk); #1; endtask
  task automatic mid; @(negedge clk); endtask

  task automatic cpu_access(input logic [AW-1:0] a, input bit we, input int dly);
    bit h = m_hit(a, we);
    logic [1:0] ec = m_cmd(a, we);
    cpu_req = 1; cpu_we = we; cpu_addr = a;
    mid;
    chk(cpu_done == h, "R2", cpu_done, h);
    if (!h) begin
      step;
      for (int k = 0; k <= dly; k++) begin
        mid;
        chk(bus_req && bus_cmd == ec && bus_addr == a, we ? "R4" : "R3", bus_cmd, ec);
        chk(!cpu_done, "R4", cpu_done, 0);
        if (k < dly) step;
      end
      step; bus_gnt = 1; bus_done = 1;
      mid;
      chk(cpu_done == !we, "R3", cpu_done, !we);
      step; bus_gnt = 0; bus_done = 0;
      if (we) begin
        mid;
        chk(cpu_done && !bus_req, "R4", cpu_done, 1);
        step;
      end
      mst[m_idx(a)] = we ? 2 : 1; mtg[m_idx(a)] = m_tag(a);
    end else step;
    cpu_req = 0;
    mid;
    chk(!bus_req, "R10", bus_req, 0);
    step;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [1:0] c);
    int i = m_idx(a);
    bit match = mtg[i] == m_tag(a);
    bit esh = match && mst[i] != 0;
    bit edy = match && mst[i] == 2;
    snp_valid = 1; snp_addr = a; snp_cmd = c;
    mid;
    chk(snp_shared == esh, "R7", snp_shared, esh);
    chk(snp_dirty == edy, (c == 2'b01) ? "R6" : "R7", snp_dirty, edy);
    chk(!snp_wait, "R11", snp_wait, 0);
    step;
    snp_valid = 0;
    if (match && mst[i] != 0) mst[i] = (c == 2'b01) ? 1 : 0;
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtg[i] = 0; end
    repeat (3) step;
    rst_n = 1;
    mid;
    chk(!bus_req && !cpu_done, "R1", bus_req, 0);
    step;
    cpu_access(8'h04, 0, 1);                 // R1 first access misses, R3
    cpu_access(8'h04, 0, 0);                 // R2 read hit in S
    cpu_access(8'h04, 1, 2);                 // R4 upgrade from S
    cpu_access(8'h04, 1, 0);                 // R2 write hit in M
    snoop(8'h04, 2'b01);                     // R6 flush, M -> S
    cpu_access(8'h04, 1, 0);                 // R6 write now needs upgrade

    // R5 race: queued upgrade loses to an observed read-for-ownership
    cpu_access(8'h09, 0, 0);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h09;
    step;
    mid; chk(bus_cmd == 2'b11, "R5", bus_cmd, 3);
    step; snp_valid = 1; snp_addr = 8'h09; snp_cmd = 2'b10;
    mid; chk(snp_shared && !snp_dirty, "R7", snp_shared, 1);
    step; snp_valid = 0;
    mid; chk(bus_req && bus_cmd == 2'b10, "R5", bus_cmd, 2);
    step; bus_gnt = 1; bus_done = 1;
    mid; chk(!cpu_done, "R4", cpu_done, 0);
    step; bus_gnt = 0; bus_done = 0;
    mid; chk(cpu_done, "R4", cpu_done, 1);
    step; cpu_req = 0; mst[1] = 2; mtg[1] = 2;

    // R8 hold: snoop in the cycle after write completion
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h0E;
    step; step; bus_gnt = 1; bus_done = 1;
    step; bus_gnt = 0; bus_done = 0;
    snp_valid = 1; snp_addr = 8'h0E; snp_cmd = 2'b10;
    mid; chk(snp_wait && !snp_shared && !snp_dirty && cpu_done, "R8", snp_wait, 1);
    step; snp_valid = 0; cpu_req = 0; mst[2] = 2; mtg[2] = 3;
    snoop(8'h0E, 2'b10);                     // R8 line still M, now invalidated

    // R11 snoop to a pending read and to a mismatched tag
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h13;
    step; snp_valid = 1; snp_addr = 8'h13; snp_cmd = 2'b10;
    mid; chk(!snp_shared && !snp_dirty, "R11", snp_shared, 0);
    step; snp_valid = 0; bus_gnt = 1; bus_done = 1;
    mid; chk(cpu_done, "R11", cpu_done, 1);
    step; bus_gnt = 0; bus_done = 0; cpu_req = 0; mst[3] = 1; mtg[3] = 4;
    cpu_access(8'h13, 0, 0);                 // R11 still S: hit
    snoop(8'h23, 2'b10);                     // R11 other tag

    // R9 snoop update stalls a processor hit on another line
    cpu_access(8'h01, 1, 0);
    cpu_access(8'h02, 0, 0);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h01;
    snp_valid = 1; snp_addr = 8'h02; snp_cmd = 2'b11;
    mid; chk(!cpu_done && snp_shared, "R9", cpu_done, 0);
    step; snp_valid = 0; mst[2] = 0;
    mid; chk(cpu_done, "R9", cpu_done, 1);
    step; cpu_req = 0;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {6'(($urandom % 3) + 1), 2'($urandom % 4)};
      if ($urandom % 3 == 0) snoop(a, 2'(($urandom % 3) + 1));
      else cpu_access(a, 1'($urandom % 2), int'($urandom % 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule